// File: doc/BRIEF.md
# Service-Level Arbiter for a Shared Single-Port RAM

This block sits in front of one single-ported on-chip RAM and decides, cycle by cycle, which of nine host ports gets to use it. Each port carries a 2-bit service level. Level 0 is background traffic, level 1 is bandwidth-sensitive, level 2 is latency-sensitive and level 3 is latency-critical. The highest level among the eligible requesters wins. When two or more eligible requesters share that level, the port with the smallest index wins. Ports at levels 0 and 1 are never served in the first cycle of a request. They must have asked in the previous cycle without being granted. Ports at levels 2 and 3 can be served in the same cycle they ask.

A host raises its request together with an address, write data and a write flag, and keeps the request high until it sees its grant. The grant is combinational within the cycle. The granted access drives the RAM pins in that same cycle. For a read, the RAM data comes back one cycle later on a shared read-data bus, together with a per-port valid strobe.

The levels are held in a small register file. There is one 32-bit word per port, selected by port index, with the level in bits [1:0]. Only full-word writes with all four byte strobes set are accepted. The last port is fixed at level 3.

Top module: `qos_ram_arbiter`

## Requirements
- R1: Among eligible requesters, the grant goes to a port whose level is numerically highest. A requesting port at level 2 or 3 never leaves a cycle with no grant at all.
- R2: When several eligible requesters share the highest level, the one with the lowest port index is granted.
- R3: A port at level 0 or 1 is granted only if it also requested in the previous cycle and was not granted then. A port at level 2 or 3 that requests alone is granted in the same cycle.
- R4: At most one grant bit is high in any cycle, and a grant bit is high only while that port's request is high.
- R5: ram_en_o is high exactly when some port is granted. ram_addr_o, ram_wdata_o and ram_we_o then carry the granted port's address, write data and write flag.
- R6: One cycle after a read grant to port i, rvalid_o[i] is high and rdata_o equals the RAM's returned data. A write grant produces no rvalid_o pulse.
- R7: After reset, the levels read back as 3 for port 0, 2 for ports 1 to 6, and 3 for ports 7 and 8.
- R8: Config word i (cfg_sel_i = i) holds port i's level in bits [1:0] and reads zero in bits [31:2]. A write with cfg_be_i other than 4'b1111 changes nothing. An accepted write affects arbitration from the next cycle on. Selectors 9 to 15 read zero.
- R9: Port 8 always reads back as level 3, and writes to its word are ignored.
- R10: A low-level port that is waiting keeps competing each cycle. A higher-level request that arrives while it waits is served first, and the waiting port is served in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 9 | Per-port access request |
| we_i | input | 9 | Per-port write flag (1 = write) |
| addr_i | input | 90 | Per-port word address, port i at bits [10i+9:10i] |
| wdata_i | input | 288 | Per-port write data, port i at bits [32i+31:32i] |
| gnt_o | output | 9 | One-hot grant, combinational in the request cycle |
| rvalid_o | output | 9 | Per-port read-data valid, one cycle after a read grant |
| rdata_o | output | 32 | Shared read data |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 10 | RAM address |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, valid one cycle after a read enable |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_be_i | input | 4 | Config byte strobes; only 4'b1111 is accepted |
| cfg_sel_i | input | 4 | Config word selector (port index) |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_rdata_o | output | 32 | Config read data for the selected word |

## Verification
The bench targets ties at the top level. A design that compares with greater-or-equal would hand a tie to the highest index instead of the lowest. It also checks the first cycle of a level-0 or level-1 request, where a missing wait bit would grant too early. It covers a waiting low-level port being overtaken by a level-2 arrival, where a stale wait flag would let the low port win or would lose its place. Partial-strobe writes, writes to the fixed port and the cycle in which a new level first takes effect are each checked at the ports. A randomized run then compares every grant and RAM address against a model that tracks waiting ports on its own.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
   localparam int LVL_W = 2;
   typedef logic [LVL_W-1:0] qos_lvl_t;

   localparam qos_lvl_t QOS_BACKGROUND = 2'd0;
   localparam qos_lvl_t QOS_BANDWIDTH  = 2'd1;
   localparam qos_lvl_t QOS_LATENCY    = 2'd2;
   localparam qos_lvl_t QOS_CRITICAL   = 2'd3;

   // levels below QOS_LATENCY must sit out one cycle before service
   function automatic logic lvl_is_slow(qos_lvl_t l);
      return (l < QOS_LATENCY);
   endfunction
endpackage

// File: rtl/qos_level_regs.sv
module qos_level_regs
   import qos_arb_pkg::*;
#(
   parameter int NUM_PORTS = 9,
   parameter int FIXED_PORT = NUM_PORTS - 1,
   parameter int SEL_W = 4,
   parameter int CFG_W = 32,
   parameter logic [NUM_PORTS*LVL_W-1:0] RESET_LEVELS = '1,
   localparam int BE_W = CFG_W / 8,
   localparam int LVLS_W = NUM_PORTS * LVL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_i,
   input  logic [BE_W-1:0]   cfg_be_i,
   input  logic [SEL_W-1:0]  cfg_sel_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   output logic [CFG_W-1:0]  cfg_rdata_o,
   output logic [LVLS_W-1:0] levels_o
);
   generate
      if (CFG_W < 8 || (CFG_W % 8) != 0 || CFG_W <= LVL_W)
         $error("qos_level_regs: CFG_W must be a byte multiple wider than a level");
      if ((1 << SEL_W) < NUM_PORTS)
         $error("qos_level_regs: SEL_W too narrow for NUM_PORTS");
   endgenerate

   logic full_write;
   logic unused_wdata_hi;
   assign full_write      = cfg_wr_i && (&cfg_be_i);
   assign unused_wdata_hi = ^cfg_wdata_i[CFG_W-1:LVL_W];

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lvl
      if (i == FIXED_PORT) begin : g_fixed
         assign levels_o[i*LVL_W +: LVL_W] = QOS_CRITICAL;
      end else begin : g_prog
         qos_lvl_t lvl_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lvl_q <= RESET_LEVELS[i*LVL_W +: LVL_W];
            else if (full_write && cfg_sel_i == SEL_W'(i))
               lvl_q <= cfg_wdata_i[LVL_W-1:0];
         end
         assign levels_o[i*LVL_W +: LVL_W] = lvl_q;
      end
   end

   always_comb begin
      cfg_rdata_o = '0;
      for (int i = 0; i < NUM_PORTS; i++)
         if (cfg_sel_i == SEL_W'(i))
            cfg_rdata_o[LVL_W-1:0] = levels_o[i*LVL_W +: LVL_W];
   end

   AST_PARTIAL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && !(&cfg_be_i)) |=> $stable(levels_o)); // R8
endmodule

// File: rtl/qos_wait_gate.sv
module qos_wait_gate
   import qos_arb_pkg::*;
#(
   parameter int NUM_PORTS = 9,
   localparam int LVLS_W = NUM_PORTS * LVL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req_i,
   input  logic [NUM_PORTS-1:0] gnt_i,
   input  logic [LVLS_W-1:0]    levels_i,
   output logic [NUM_PORTS-1:0] elig_o
);
   logic [NUM_PORTS-1:0] waited_q;

   // a port has "waited" when it asked last cycle and was passed over
   always_ff @(posedge clk) begin
      if (!rst_n) waited_q <= '0;
      else        waited_q <= req_i & ~gnt_i;
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_elig
      assign elig_o[i] = req_i[i] &&
         (!lvl_is_slow(levels_i[i*LVL_W +: LVL_W]) || waited_q[i]);
   end
endmodule

// File: rtl/qos_prio_pick.sv
module qos_prio_pick
   import qos_arb_pkg::*;
#(
   parameter int NUM_PORTS = 9,
   localparam int LVLS_W = NUM_PORTS * LVL_W,
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [NUM_PORTS-1:0] elig_i,
   input  logic [LVLS_W-1:0]    levels_i,
   output logic [NUM_PORTS-1:0] gnt_o
);
   logic             found;
   qos_lvl_t         best;
   logic [IDX_W-1:0] win;

   // strict greater-than keeps the lowest index among equals
   always_comb begin
      found = 1'b0;
      best  = '0;
      win   = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (elig_i[i] && (!found || levels_i[i*LVL_W +: LVL_W] > best)) begin
            found = 1'b1;
            best  = levels_i[i*LVL_W +: LVL_W];
            win   = IDX_W'(i);
         end
      end
      gnt_o = '0;
      if (found) gnt_o[win] = 1'b1;
   end
endmodule

// File: rtl/qos_ram_arbiter.sv
module qos_ram_arbiter
   import qos_arb_pkg::*;
#(
   parameter int NUM_PORTS = 9,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int SEL_W = 4,
   parameter int CFG_W = 32,
   parameter logic [NUM_PORTS*LVL_W-1:0] RESET_LEVELS = 18'b11_11_10_10_10_10_10_10_11,
   localparam int LVLS_W = NUM_PORTS * LVL_W,
   localparam int BE_W = CFG_W / 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        req_i,
   input  logic [NUM_PORTS-1:0]        we_i,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
   output logic [NUM_PORTS-1:0]        gnt_o,
   output logic [NUM_PORTS-1:0]        rvalid_o,
   output logic [DATA_W-1:0]           rdata_o,
   output logic                        ram_en_o,
   output logic                        ram_we_o,
   output logic [ADDR_W-1:0]           ram_addr_o,
   output logic [DATA_W-1:0]           ram_wdata_o,
   input  logic [DATA_W-1:0]           ram_rdata_i,
   input  logic                        cfg_wr_i,
   input  logic [BE_W-1:0]             cfg_be_i,
   input  logic [SEL_W-1:0]            cfg_sel_i,
   input  logic [CFG_W-1:0]            cfg_wdata_i,
   output logic [CFG_W-1:0]            cfg_rdata_o
);
   generate
      if (NUM_PORTS < 2) $error("qos_ram_arbiter: needs at least two ports");
      if (ADDR_W < 1 || DATA_W < 1) $error("qos_ram_arbiter: bad RAM widths");
   endgenerate

   logic [LVLS_W-1:0]    levels;
   logic [NUM_PORTS-1:0] elig;

   qos_level_regs #(
      .NUM_PORTS(NUM_PORTS), .FIXED_PORT(NUM_PORTS-1), .SEL_W(SEL_W),
      .CFG_W(CFG_W), .RESET_LEVELS(RESET_LEVELS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_be_i(cfg_be_i),
      .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_rdata_o(cfg_rdata_o), .levels_o(levels)
   );

   qos_wait_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_i(gnt_o),
      .levels_i(levels), .elig_o(elig)
   );

   qos_prio_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
      .elig_i(elig), .levels_i(levels), .gnt_o(gnt_o)
   );

   always_comb begin
      ram_en_o    = |gnt_o;
      ram_we_o    = 1'b0;
      ram_addr_o  = '0;
      ram_wdata_o = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (gnt_o[i]) begin
            ram_we_o    = we_i[i];
            ram_addr_o  = addr_i[i*ADDR_W +: ADDR_W];
            ram_wdata_o = wdata_i[i*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid_o <= '0;
      else        rvalid_o <= gnt_o & ~we_i;
   end
   assign rdata_o = ram_rdata_i;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R4
   AST_RAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> !ram_en_o); // R5

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
      AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[i] |-> req_i[i]); // R4
      AST_SLOW_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_o[i] && lvl_is_slow(levels[i*LVL_W +: LVL_W]))
            |-> $past(req_i[i] && !gnt_o[i])); // R3
      AST_FAST_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
         (req_i[i] && !lvl_is_slow(levels[i*LVL_W +: LVL_W])) |-> (gnt_o != '0)); // R1
      AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         rvalid_o[i] |-> $past(gnt_o[i] && !we_i[i])); // R6
   end
endmodule

// File: tb/qos_ram_arbiter_test.sv
module qos_ram_arbiter_test;
   localparam int N = 9;
   localparam int AW = 10;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req = '0, we = '0;
   logic [N*AW-1:0] addr = '0;
   logic [N*DW-1:0] wdata = '0;
   logic [N-1:0] gnt, rvalid;
   logic [DW-1:0] rdata, ram_wdata, ram_rdata;
   logic ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic cfg_wr = 1'b0;
   logic [3:0] cfg_be = '0, cfg_sel = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;

   int checks = 0;
   int errors = 0;
   int lv [N];

   always #2.5 clk = ~clk;

   qos_ram_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata),
      .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
      .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .cfg_wr_i(cfg_wr),
      .cfg_be_i(cfg_be), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata)
   );

   function automatic logic [DW-1:0] ram_val(logic [AW-1:0] a);
      return {12'hC0D, a, a} ^ 32'h0000_5A5A;
   endfunction

   always @(posedge clk)
      if (ram_en && !ram_we) ram_rdata <= ram_val(ram_addr);

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(int sel, logic [3:0] be, logic [31:0] d);
      cfg_wr = 1'b1; cfg_be = be; cfg_sel = 4'(sel); cfg_wdata = d;
      tick();
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_read(int sel, output logic [31:0] d);
      cfg_sel = 4'(sel);
      #1 d = cfg_rdata;
   endtask

   task automatic set_port(int i, logic [AW-1:0] a, logic [DW-1:0] d, logic w);
      addr[i*AW +: AW] = a;
      wdata[i*DW +: DW] = d;
      we[i] = w;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      #1 chk("R4 reset grant", 32'(gnt), 0);
      chk("R5 reset ram_en", 32'(ram_en), 0);
      chk("R6 reset rvalid", 32'(rvalid), 0);
      for (int i = 0; i < N; i++) begin
         cfg_read(i, d);
         chk($sformatf("R7 reset level port %0d", i), d, 32'(lv[i]));
      end
      cfg_read(12, d);
      chk("R8 unused selector reads zero", d, 0);
   endtask

   task automatic t_priority();
      req = '1;
      #1 chk("R2 top-level tie among 0,7,8", 32'(gnt), 32'h001);
      tick();
      req = 9'b0_0111_1110;
      #1 chk("R2 level-2 tie among 1..6", 32'(gnt), 32'h002);
      tick();
      req = 9'b1_0000_1000;
      #1 chk("R1 level 3 beats level 2", 32'(gnt), 32'h100);
      tick();
      req = '0;
      tick();
   endtask

   task automatic t_mux();
      set_port(5, 10'h1A3, 32'h1111_2222, 1'b0);
      req = 9'b0_0010_0000;
      #1 chk("R5 read grant", 32'(gnt), 32'h020);
      chk("R5 ram_en", 32'(ram_en), 1);
      chk("R5 ram_we read", 32'(ram_we), 0);
      chk("R5 ram_addr", 32'(ram_addr), 32'h1A3);
      tick();
      req = '0;
      #1 chk("R6 rvalid after read", 32'(rvalid), 32'h020);
      chk("R6 rdata", rdata, ram_val(10'h1A3));
      tick();
      set_port(6, 10'h055, 32'hDEAD_BEEF, 1'b1);
      req = 9'b0_0100_0000;
      #1 chk("R5 ram_we write", 32'(ram_we), 1);
      chk("R5 ram_wdata", ram_wdata, 32'hDEAD_BEEF);
      chk("R5 ram_addr write", 32'(ram_addr), 32'h055);
      tick();
      req = '0;
      #1 chk("R6 no rvalid after write", 32'(rvalid), 0);
      tick();
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      cfg_write(1, 4'b0011, 32'h0);
      cfg_read(1, d);
      chk("R8 partial write ignored", d, 2);
      cfg_write(1, 4'b1111, 32'hFFFF_FFF1);
      cfg_read(1, d);
      chk("R8 full write, upper bits zero", d, 1);
      lv[1] = 1;
      cfg_write(8, 4'b1111, 32'h0);
      cfg_read(8, d);
      chk("R9 fixed port stays 3", d, 3);
      req = 9'b1_0000_0000;
      #1 chk("R9 port 8 served at once", 32'(gnt), 32'h100);
      tick();
      req = '0;
      // raise port 3 to level 3: it must now beat port 2
      cfg_write(3, 4'b1111, 32'h3);
      lv[3] = 3;
      req = 9'b0_0000_1100;
      #1 chk("R8 new level in effect next cycle", 32'(gnt), 32'h008);
      tick();
      req = '0;
      tick();
   endtask

   task automatic t_slow();
      cfg_write(4, 4'b1111, 32'h0);
      lv[4] = 0;
      req = 9'b0_0001_0000;
      #1 chk("R3 level 0 not served first cycle", 32'(gnt), 0);
      chk("R5 ram idle while waiting", 32'(ram_en), 0);
      tick();
      #1 chk("R3 level 0 served second cycle", 32'(gnt), 32'h010);
      tick();
      req = '0;
      tick();
      req = 9'b0_0000_0010;
      #1 chk("R3 level 1 not served first cycle", 32'(gnt), 0);
      tick();
      #1 chk("R3 level 1 served second cycle", 32'(gnt), 32'h002);
      tick();
      req = '0;
      tick();
   endtask

   task automatic t_contest();
      req = 9'b0_0001_0000;
      #1 chk("R10 waiting port not yet served", 32'(gnt), 0);
      tick();
      req = 9'b0_0001_0100;
      #1 chk("R10 higher arrival served first", 32'(gnt), 32'h004);
      tick();
      req = 9'b0_0001_0000;
      #1 chk("R10 waiting port served next", 32'(gnt), 32'h010);
      tick();
      req = '0;
      tick();
   endtask

   task automatic t_random();
      logic [N-1:0] waited = '0;
      logic [N-1:0] exp;
      int bl, bi;
      int setl [N] = '{1, 0, 3, 2, 1, 0, 2, 3, 3};
      for (int i = 0; i < N - 1; i++) begin
         cfg_write(i, 4'b1111, 32'(setl[i]));
         lv[i] = setl[i];
      end
      for (int i = 0; i < N; i++) set_port(i, 10'(i * 37 + 5), 32'(i), 1'b0);
      for (int c = 0; c < 400; c++) begin
         req = 9'($urandom);
         bl = -1; bi = -1;
         for (int i = 0; i < N; i++)
            if (req[i] && (lv[i] >= 2 || waited[i]) && lv[i] > bl) begin
               bl = lv[i]; bi = i;
            end
         exp = '0;
         if (bi >= 0) exp[bi] = 1'b1;
         #1 chk("R1 R2 R3 model grant", 32'(gnt), 32'(exp));
         if (bi >= 0) chk("R5 model address", 32'(ram_addr), 32'(bi * 37 + 5));
         waited = req & ~exp;
         tick();
      end
      req = '0;
      tick();
   endtask

   initial begin
      lv = '{3, 2, 2, 2, 2, 2, 2, 3, 3};
      ram_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_priority();
      t_mux();
      t_cfg();
      t_slow();
      t_contest();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule